// File: doc/BRIEF.md
# Synchronous Burst SRAM

This block is a synchronous static RAM with a small internal array and a two-bit burst counter. The word is 18 bits wide with two 9-bit byte lanes, or 36 bits wide with four. Every control input is sampled on the rising clock edge. These inputs are three chip selects, two address strobes (one for the processor side, one for the controller side), a burst-advance input, a byte-write enable with one select per lane, and a global write. Output enable and a sleep input act on the data bus at once, without waiting for a clock edge.

An address strobe with the chip selected loads a new external address. The two low address bits then step through a group of four under the advance input. A mode input chooses whether those low bits count linearly or interleaved. A second mode input chooses how read data reaches the bus. In flow-through mode it bypasses an output register. In pipelined mode it passes through that register, which adds one clock of latency. A new address can be loaded on every cycle, so single accesses can run back to back without using bursts.

Top module: `sbsram_core`

## Requirements
- R1: The chip is selected only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. A strobe seen while the chip is not selected ends any burst and performs no write. Read data leaves the bus one cycle later in flow-through mode and two cycles later in pipelined mode.
- R2: While `ce1_n`=1, `ads_cpu_n` is ignored. The cycle behaves as if no strobe were present.
- R3: A load clears the 2-bit burst count. In a cycle with no strobe during an active burst:
  - the count advances by one, wrapping inside the aligned group of four, when `adv_n`=0;
  - the same address is accessed again when `adv_n`=1.
- R4: With `lin_order`=1, the low address bits are (start + count) mod 4. With `lin_order`=0, they are start XOR count. The upper address bits stay fixed for the whole burst.
- R5: With `pipe_sel`=0 (flow-through), read data is on `dout`, with `dq_oe`=1, in the clock period that follows the edge that sampled its address.
- R6: With `pipe_sel`=1 (pipelined), read data appears one clock period later than in flow-through mode.
- R7: Lane i, which is bits [9i+8:9i], is written only when `bwe_n`=0 and `bsel_n[i]`=0. Lane selects without `bwe_n`=0 write nothing, and the cycle is a read.
- R8: `gw_n`=0 writes every lane, whatever the values of `bwe_n` and `bsel_n`.
- R9: A new address can be loaded on every cycle. Consecutive single reads each return their own word.
- R10: `dq_oe` is 0 in any of these cases:
  - `oe_n`=1, with immediate effect;
  - the current cycle is a write;
  - no read is pending.
- R11: While `sleep`=1, `dq_oe` is 0 with immediate effect, all synchronous inputs are ignored, and the memory contents are kept.
- R12: After reset, no burst is active and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| ce1_n | input | 1 | Chip select, active low; also gates the processor strobe |
| ce2 | input | 1 | Chip select, active high |
| ce3_n | input | 1 | Chip select, active low |
| ads_cpu_n | input | 1 | Processor-side address strobe, active low |
| ads_ctl_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| bwe_n | input | 1 | Byte-write enable, active low |
| bsel_n | input | WORD_W/9 | Per-lane write selects, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| lin_order | input | 1 | 1 selects linear burst order, 0 selects interleaved |
| pipe_sel | input | 1 | 1 selects pipelined reads, 0 selects flow-through |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Low-power hold, active high, asynchronous |
| addr | input | AW | Word address |
| din | input | WORD_W | Write data |
| dout | output | WORD_W | Read data |
| dq_oe | output | 1 | High when the block drives read data onto the bus |

## Verification
A count or base register that is corrupted shows up at the ports as the wrong word on the very next read. Flow-through mode exposes it in the following clock period and pipelined mode one period later. Burst-order errors appear only on the second to fourth beats of a burst, so the bench checks full bursts in both orders and both read modes. A lost or extra deselect shows up as `dq_oe` staying high, or dropping one cycle too early, relative to the mode's latency. A write leaking through in a deselected or sleeping cycle stays hidden until that address is read back later.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

  localparam int LANE_W = 9;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_CONT  = 2'd2,
    ACC_DESEL = 2'd3
  } acc_kind_e;

  // Low two address bits for burst beat `cnt` starting at `start`.
  function automatic logic [1:0] burst_lo(input logic [1:0] start,
                                          input logic [1:0] cnt,
                                          input logic       lin);
    if (lin) return 2'(start + cnt);
    return start ^ cnt;
  endfunction

  // One lane's write strobe from the active-low write controls.
  function automatic logic lane_write(input logic gw_n_i,
                                      input logic bwe_n_i,
                                      input logic bsel_n_i);
    return !gw_n_i || (!bwe_n_i && !bsel_n_i);
  endfunction

endpackage

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce1_n,
  input  logic             ce2,
  input  logic             ce3_n,
  input  logic             ads_cpu_n,
  input  logic             ads_ctl_n,
  input  logic             adv_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  input  logic             gw_n,
  input  logic             lin_order,
  input  logic             sleep,
  input  logic [AW-1:0]    addr,
  output acc_kind_e        kind,
  output logic [LANES-1:0] lane_we,
  output logic             wr_now,
  output logic [AW-1:0]    acc_addr,
  output logic [1:0]       cnt_q,
  output logic [AW-1:0]    rd_addr_q,
  output logic             rd_q
);

  logic          selected;
  logic          cpu_take;
  logic          strobe;
  logic          access;
  logic          active_q;
  logic [AW-1:0] base_q;
  logic [AW-1:0] base_now;
  logic [1:0]    cnt_now;

  assign selected = !ce1_n && ce2 && !ce3_n;
  assign cpu_take = !ads_cpu_n && !ce1_n;
  assign strobe   = cpu_take || !ads_ctl_n;

  always_comb begin
    if (sleep)                   kind = ACC_NONE;
    else if (strobe && selected) kind = ACC_LOAD;
    else if (strobe)             kind = ACC_DESEL;
    else if (active_q)           kind = ACC_CONT;
    else                         kind = ACC_NONE;
  end

  assign access   = (kind == ACC_LOAD) || (kind == ACC_CONT);
  assign base_now = (kind == ACC_LOAD) ? addr : base_q;

  always_comb begin
    if (kind == ACC_LOAD)                cnt_now = 2'd0;
    else if (kind == ACC_CONT && !adv_n) cnt_now = cnt_q + 2'd1;
    else                                 cnt_now = cnt_q;
  end

  assign acc_addr = {base_now[AW-1:2], burst_lo(base_now[1:0], cnt_now, lin_order)};

  for (genvar g = 0; g < LANES; g++) begin : g_we
    assign lane_we[g] = access && lane_write(gw_n, bwe_n, bsel_n[g]);
  end
  assign wr_now = |lane_we;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      base_q    <= '0;
      cnt_q     <= 2'd0;
      rd_q      <= 1'b0;
      rd_addr_q <= '0;
    end else if (!sleep) begin
      case (kind)
        ACC_LOAD: begin
          active_q <= 1'b1;
          base_q   <= addr;
          cnt_q    <= 2'd0;
        end
        ACC_CONT:  cnt_q    <= cnt_now;
        ACC_DESEL: active_q <= 1'b0;
        default: ;
      endcase
      rd_q      <= access && !wr_now;
      rd_addr_q <= acc_addr;
    end
  end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        lane_we,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[g]) mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
    end

    assign rdata[g*LANE_W +: LANE_W] = mem[rd_addr];
  end

endmodule

// File: rtl/sbsram_outstage.sv
module sbsram_outstage #(
  parameter int WORD_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep,
  input  logic              pipe_sel,
  input  logic              oe_n,
  input  logic              wr_now,
  input  logic              rd_q,
  input  logic [WORD_W-1:0] rdata,
  output logic [WORD_W-1:0] dout,
  output logic              dq_oe
);

  logic              pv_q;
  logic [WORD_W-1:0] pd_q;
  logic              have_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pv_q <= 1'b0;
      pd_q <= '0;
    end else if (!sleep) begin
      pv_q <= rd_q;
      pd_q <= rdata;
    end
  end

  assign have_data = pipe_sel ? pv_q : rd_q;
  assign dout      = pipe_sel ? pd_q : rdata;
  assign dq_oe     = have_data && !oe_n && !sleep && !wr_now;

endmodule

// File: rtl/sbsram_core.sv
module sbsram_core
  import sbsram_pkg::*;
#(
  parameter int WORD_W = 18,
  parameter int AW     = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ce1_n,
  input  logic                   ce2,
  input  logic                   ce3_n,
  input  logic                   ads_cpu_n,
  input  logic                   ads_ctl_n,
  input  logic                   adv_n,
  input  logic                   bwe_n,
  input  logic [WORD_W/9-1:0]    bsel_n,
  input  logic                   gw_n,
  input  logic                   lin_order,
  input  logic                   pipe_sel,
  input  logic                   oe_n,
  input  logic                   sleep,
  input  logic [AW-1:0]          addr,
  input  logic [WORD_W-1:0]      din,
  output logic [WORD_W-1:0]      dout,
  output logic                   dq_oe
);

  localparam int LANES = WORD_W / LANE_W;

  acc_kind_e        acc_kind;
  logic [LANES-1:0] lane_we;
  logic             wr_now;
  logic [AW-1:0]    acc_addr;
  logic [1:0]       cnt_q;
  logic [AW-1:0]    rd_addr_q;
  logic             rd_q;
  logic [WORD_W-1:0] rdata;

  sbsram_ctrl #(.AW(AW), .LANES(LANES)) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .gw_n(gw_n),
    .lin_order(lin_order), .sleep(sleep), .addr(addr),
    .kind(acc_kind), .lane_we(lane_we), .wr_now(wr_now),
    .acc_addr(acc_addr), .cnt_q(cnt_q),
    .rd_addr_q(rd_addr_q), .rd_q(rd_q)
  );

  sbsram_array #(.AW(AW), .LANES(LANES)) array_i (
    .clk(clk), .lane_we(lane_we), .wr_addr(acc_addr),
    .wdata(din), .rd_addr(rd_addr_q), .rdata(rdata)
  );

  sbsram_outstage #(.WORD_W(WORD_W)) out_i (
    .clk(clk), .rst_n(rst_n), .sleep(sleep), .pipe_sel(pipe_sel),
    .oe_n(oe_n), .wr_now(wr_now), .rd_q(rd_q), .rdata(rdata),
    .dout(dout), .dq_oe(dq_oe)
  );

endmodule

// File: rtl/sbsram_core_chk.sv
module sbsram_core_chk
  import sbsram_pkg::*;
#(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input acc_kind_e        kind,
  input logic [1:0]       cnt_q,
  input logic             adv_n,
  input logic             gw_n,
  input logic             oe_n,
  input logic             sleep,
  input logic             pipe_sel,
  input logic             wr_now,
  input logic [LANES-1:0] lane_we,
  input logic             dq_oe
);

  AST_OE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !dq_oe);  // R10

  AST_WRITE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_now |-> !dq_oe);  // R10

  AST_SLEEP_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> !dq_oe);  // R11

  AST_SLEEP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |-> (lane_we == '0));  // R11

  AST_LOAD_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_LOAD) |=> (cnt_q == 2'd0));  // R3

  AST_ADV_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_CONT && !adv_n) |=> (cnt_q == $past(cnt_q) + 2'd1));  // R3

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_CONT && adv_n) |=> $stable(cnt_q));  // R3

  AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    ((kind == ACC_LOAD || kind == ACC_CONT) && !gw_n) |-> (&lane_we));  // R8

  AST_DESEL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_DESEL) |-> (lane_we == '0));  // R1

  AST_DESEL_FLOW_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_DESEL && !pipe_sel) |=> (pipe_sel || !dq_oe));  // R1

endmodule

bind sbsram_core sbsram_core_chk #(.LANES(LANES)) chk_i (
  .clk(clk), .rst_n(rst_n), .kind(acc_kind), .cnt_q(cnt_q),
  .adv_n(adv_n), .gw_n(gw_n), .oe_n(oe_n), .sleep(sleep),
  .pipe_sel(pipe_sel), .wr_now(wr_now), .lane_we(lane_we), .dq_oe(dq_oe)
);

// File: tb/sbsram_core_tb_top.sv
`timescale 1ns/1ps
module sbsram_core_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ce1_n, ce2, ce3_n;
  logic        ads_cpu_n, ads_ctl_n, adv_n;
  logic        bwe_n, gw_n;
  logic [1:0]  bsel_n;
  logic        lin_order, pipe_sel, oe_n, sleep;
  logic [5:0]  addr;
  logic [17:0] din;
  logic [17:0] dout;
  logic        dq_oe;

  sbsram_core dut_i (
    .clk(clk), .rst_n(rst_n), .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n),
    .ads_cpu_n(ads_cpu_n), .ads_ctl_n(ads_ctl_n), .adv_n(adv_n),
    .bwe_n(bwe_n), .bsel_n(bsel_n), .gw_n(gw_n),
    .lin_order(lin_order), .pipe_sel(pipe_sel), .oe_n(oe_n), .sleep(sleep),
    .addr(addr), .din(din), .dout(dout), .dq_oe(dq_oe)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    bit          oe;
    logic [17:0] d;
    string       tag;
  } exp_t;

  exp_t        sbq[$];
  int          n_chk  = 0;
  int          n_fail = 0;
  bit          sb_on  = 1'b1;
  bit          done   = 1'b0;
  logic [17:0] ref_mem [64];
  logic [5:0]  tb_base = '0;
  int          tb_cnt  = 0;

  task automatic chk(input bit ok, input string tag,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Monitor: compare the bus against queued expectations at mid-cycle.
  initial begin
    forever begin
      @(negedge clk);
      while (sbq.size() > 0 && sbq[0].due <= cyc) begin
        exp_t e;
        e = sbq.pop_front();
        if (e.due < cyc)
          chk(1'b0, {e.tag, " (missed slot)"}, 32'(cyc), 32'(e.due));
        else if (e.oe)
          chk(dq_oe === 1'b1 && dout === e.d, e.tag, {13'd0, dq_oe, dout}, {13'd0, 1'b1, e.d});
        else
          chk(dq_oe === 1'b0, e.tag, 32'(dq_oe), 32'd0);
      end
    end
  end

  function automatic logic [1:0] tb_lo(input logic [1:0] b, input int c, input logic lin);
    int         s;
    logic [1:0] cc;
    cc = c[1:0];
    s  = (int'(b) + c) % 4;
    if (lin) return s[1:0];
    return {b[1] ^ cc[1], b[0] ^ cc[0]};
  endfunction

  task automatic set_idle();
    ce1_n = 0; ce2 = 1; ce3_n = 0;
    ads_cpu_n = 1; ads_ctl_n = 1; adv_n = 1;
    bwe_n = 1; bsel_n = 2'b11; gw_n = 1;
    oe_n = 0; sleep = 0; addr = '0; din = '0;
  endtask

  task automatic cyc_go();
    @(posedge clk);
    #1;
    set_idle();
  endtask

  // Reference effect of one access at address a, expectation for reads.
  task automatic note_access(input logic [5:0] a, input logic g, input logic bw,
                             input logic [1:0] bs, input logic [17:0] d, input string tag);
    bit w0, w1;
    w0 = !g || (!bw && !bs[0]);
    w1 = !g || (!bw && !bs[1]);
    if (w0 || w1) begin
      if (w0) ref_mem[a][8:0]  = d[8:0];
      if (w1) ref_mem[a][17:9] = d[17:9];
    end else if (sb_on) begin
      sbq.push_back('{due: pipe_sel ? cyc + 2 : cyc + 1, oe: 1'b1, d: ref_mem[a], tag: tag});
    end
  endtask

  task automatic load(input logic [5:0] a, input bit cpu, input logic g, input logic bw,
                      input logic [1:0] bs, input logic [17:0] d, input string tag);
    if (cpu) ads_cpu_n = 0; else ads_ctl_n = 0;
    addr = a; gw_n = g; bwe_n = bw; bsel_n = bs; din = d;
    tb_base = a; tb_cnt = 0;
    note_access(a, g, bw, bs, d, tag);
    cyc_go();
  endtask

  task automatic cont(input bit adv, input logic g, input logic bw, input logic [1:0] bs,
                      input logic [17:0] d, input bit probe, input string tag);
    logic [5:0] a;
    adv_n = !adv; gw_n = g; bwe_n = bw; bsel_n = bs; din = d;
    if (adv) tb_cnt = (tb_cnt + 1) % 4;
    a = {tb_base[5:2], tb_lo(tb_base[1:0], tb_cnt, lin_order)};
    note_access(a, g, bw, bs, d, tag);
    if (probe) begin
      #1;
      chk(dq_oe === 1'b0, tag, 32'(dq_oe), 32'd0);
    end
    cyc_go();
  endtask

  task automatic desel(input bit with_wr, input logic [5:0] a, input logic [17:0] d,
                       input string tag);
    ads_ctl_n = 0;
    if (with_wr) begin ce3_n = 1; gw_n = 0; addr = a; din = d; end
    else ce2 = 0;
    sbq.push_back('{due: pipe_sel ? cyc + 2 : cyc + 1, oe: 1'b0, d: '0, tag: tag});
    cyc_go();
  endtask

  task automatic rd(input logic [5:0] a, input string tag);
    load(a, 1'b0, 1'b1, 1'b1, 2'b11, '0, tag);
  endtask

  initial begin
    #(4 * 50000);
    chk(1'b0, "watchdog expired (all)", 32'(cyc), 32'd0);
    report();
  end

  initial begin
    set_idle();
    lin_order = 1'b1;
    pipe_sel  = 1'b0;
    rst_n     = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #1 chk(dq_oe === 1'b0, "R12 bus idle after reset", 32'(dq_oe), 32'd0);
    cyc_go();

    // R8 R9: back-to-back global writes fill the first sixteen words.
    for (int i = 0; i < 16; i++)
      load(6'(i), 1'b0, 1'b0, 1'b1, 2'b11, 18'(i * 5021 + 77), "fill");
    desel(1'b0, '0, '0, "R1 off after fill");
    cyc_go();

    // R4 R5 R3: flow-through, linear burst from 5, wrap and hold.
    load(6'd5, 1'b1, 1'b1, 1'b1, 2'b11, '0, "R5 flow first beat");
    cont(1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R4 linear beat 1");
    cont(1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R4 linear beat 2");
    cont(1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R4 linear beat 3");
    cont(1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R3 wrap to start");
    cont(1'b0, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R3 hold without advance");
    desel(1'b0, '0, '0, "R1 flow deselect after one cycle");
    cyc_go();

    // R4 R6: pipelined, interleaved burst from 6.
    pipe_sel = 1'b1; lin_order = 1'b0;
    cyc_go();
    load(6'd6, 1'b1, 1'b1, 1'b1, 2'b11, '0, "R6 pipe first beat");
    cont(1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R4 interleaved beat 1");
    cont(1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R4 interleaved beat 2");
    cont(1'b1, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R4 interleaved beat 3");
    desel(1'b0, '0, '0, "R1 pipe deselect");
    cyc_go(); cyc_go();

    // R9 R6: a new address every cycle in pipelined mode.
    rd(6'd1,  "R9 pipe single 1");
    rd(6'd9,  "R9 pipe single 9");
    rd(6'd3,  "R9 pipe single 3");
    rd(6'd14, "R9 pipe single 14");
    desel(1'b0, '0, '0, "R1 pipe deselect 2");
    cyc_go(); cyc_go();

    // R7 R8: lane writes in flow-through mode.
    pipe_sel = 1'b0; lin_order = 1'b1;
    cyc_go();
    load(6'd2, 1'b0, 1'b1, 1'b0, 2'b10, 18'h2A5A5, "wr lane0");
    load(6'd3, 1'b0, 1'b1, 1'b0, 2'b01, 18'h15C3C, "wr lane1");
    load(6'd4, 1'b0, 1'b0, 1'b1, 2'b11, 18'h3F00F, "wr global");
    load(6'd5, 1'b0, 1'b1, 1'b1, 2'b00, 18'h00FFF, "R7 selects without enable read");
    desel(1'b0, '0, '0, "R1 off after writes");
    cyc_go();
    rd(6'd2, "R7 lane0 only");
    rd(6'd3, "R7 lane1 only");
    rd(6'd4, "R8 global overrides enables");
    desel(1'b0, '0, '0, "R1 off 3");
    cyc_go();

    // R2: processor strobe ignored with ce1_n high.
    rd(6'd8, "R2 burst at 8");
    ce1_n = 1'b1; ads_cpu_n = 1'b0; addr = 6'd12;
    cont(1'b0, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R2 strobe ignored");
    desel(1'b0, '0, '0, "R1 off 4");
    cyc_go();

    // R1: write attempted while not selected.
    desel(1'b1, 6'd10, 18'h12345, "R1 off unselected write");
    cyc_go();
    rd(6'd10, "R1 unselected write not stored");
    desel(1'b0, '0, '0, "R1 off 5");
    cyc_go();

    // R10: output enable and write cycles mute the bus.
    sb_on = 1'b0;
    rd(6'd11, "read 11");
    oe_n = 1'b1;
    cont(1'b0, 1'b1, 1'b1, 2'b11, '0, 1'b1, "R10 oe_n mutes bus");
    sb_on = 1'b1;
    cont(1'b0, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R10 bus back after oe_n");
    sb_on = 1'b0;
    cont(1'b0, 1'b1, 1'b1, 2'b11, '0, 1'b0, "hold 11");
    sb_on = 1'b1;
    cont(1'b0, 1'b0, 1'b1, 2'b11, 18'h2BEEF, 1'b1, "R10 write cycle mutes bus");
    cont(1'b0, 1'b1, 1'b1, 2'b11, '0, 1'b0, "R8 burst write readback");
    desel(1'b0, '0, '0, "R1 off 6");
    cyc_go();

    // R11: sleep mutes the bus and blocks a write.
    sleep = 1'b1; ads_ctl_n = 1'b0; gw_n = 1'b0; addr = 6'd12; din = 18'h3AAAA;
    #1 chk(dq_oe === 1'b0, "R11 sleep mutes bus", 32'(dq_oe), 32'd0);
    cyc_go();
    cyc_go();
    rd(6'd12, "R11 contents kept, write ignored");
    desel(1'b0, '0, '0, "R1 off 7");

    repeat (4) cyc_go();
    chk(sbq.size() == 0, "scoreboard drained (all)", 32'(sbq.size()), 32'd0);
    report();
  end

endmodule